// File: doc/BRIEF.md
# GPIO Pad Event and Wake Controller

This block turns the synchronized input levels of one community of GPIO pads into per-pad event status, a combined interrupt line and a wake line. Pads are arranged in groups of 24. Each pad has three inputs that together set what counts as an event. A 2-bit mode selects level, single edge, both edges or off. An inversion bit flips the input before detection. A route flag marks a pad whose wake is handled elsewhere. Falling-edge and active-low sensing are therefore built from inversion and not from modes of their own.

Every group has four 32-bit words on a small register port: interrupt status, interrupt enable, wake status and wake enable. Both status words are cleared by writing ones. The host reads the per-group pending vectors, or simply waits on the interrupt line, and then clears what it has handled. Initialization writes zero to the enable words and all ones to the status words. Reset does the same.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: Register addresses are bytes. Bits 7:6 select the bank: 0 is interrupt status, 1 is interrupt enable, 2 is wake status and 3 is wake enable. Bits 5:2 give the group, and consecutive groups are 4 bytes apart. Bit k of a group word belongs to pad group*24+k. Enable words read back as written. An access with bits 1:0 not zero, or to a group that does not exist, reads 0 and writes nothing.
- R2: In mode 0 (level), the status bit is set on every clock edge at which the effective input is 1. A write-1 clear has no lasting effect while that level is present.
- R3: In mode 1 (edge), a 0-to-1 change of the effective input sets the status bit at the first clock edge after the change. A 1-to-0 change sets nothing.
- R4: In mode 3 (both edges), a change of the effective input in either direction sets the status bit at the first clock edge after the change.
- R5: In mode 2 (off), the pad never sets interrupt or wake status, whatever its input does.
- R6: The effective input is the pad input XOR the pad's inversion bit. Edge mode with inversion detects falling edges, and level mode with inversion detects a low level.
- R7: Writing a status word clears exactly those pads whose bit is 1 in the written data. A bit written as 0 leaves its pad's status unchanged. A new event in the same cycle as a clear wins.
- R8: pendingVec bit k of group g equals status AND interrupt enable for that pad. Bit positions at or above 24, and positions past the community's pad count in the last group, are always 0.
- R9: irqOut is the OR of all pendingVec bits, delayed by one register stage.
- R10: Wake status is set by the same events as interrupt status, independent of the interrupt enable, and it is cleared by writing ones. wakeOut is the registered OR, over all pads, of wake status AND wake enable AND NOT sciRoute.
- R11: After reset, all status and enable bits are 0 and irqOut and wakeOut are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| padIn | input | NUM_PADS | Synchronized pad input levels |
| padMode | input | 2*NUM_PADS | Per-pad event mode, pad p at bits 2p+1:2p |
| padInv | input | NUM_PADS | Per-pad input inversion |
| sciRoute | input | NUM_PADS | Per-pad route flag; blocks that pad's wake when set |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| pendingVec | output | NUM_GROUPS*32 | Enabled pending bits, group g at bits 32g+31:32g |
| irqOut | output | 1 | Combined interrupt |
| wakeOut | output | 1 | Combined wake |

## Verification
The bench builds the block with NUM_PADS = 40, which gives two groups, the second holding only 16 pads. This brings the cross-group addressing, the group-1 bit mapping (pad 30 at bit 6, pad 39 at bit 15) and the masking of the last group's unused positions within reach. A read of the absent third group is also covered. With 40 pads there are enough distinct pads to exercise every mode and inversion combination on pads that have no history, so the timing of each edge case is measured from a known quiet state.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int GRP_IDX_W  = 4;
  localparam int REG_ADDR_W = 8;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_OFF   = 2'd2,
    MODE_BOTH  = 2'd3
  } evMode_e;

  typedef enum logic [1:0] {
    BANK_STS  = 2'd0,
    BANK_IEN  = 2'd1,
    BANK_WSTS = 2'd2,
    BANK_WEN  = 2'd3
  } bank_e;

  typedef struct packed {
    logic                 wrSts;
    logic                 wrIen;
    logic                 wrWsts;
    logic                 wrWen;
    bank_e                rdBank;
    logic                 grpHit;
    logic [GRP_IDX_W-1:0] grp;
  } regStrobe_t;

endpackage

// File: rtl/gpio_evt_decode.sv
module gpio_evt_decode
  import gpio_evt_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output regStrobe_t            strobe
);

  localparam logic [GRP_IDX_W:0] GROUP_LIMIT = (GRP_IDX_W+1)'(NUM_GROUPS);

  logic [GRP_IDX_W-1:0] grpSel;
  bank_e                bankSel;
  logic                 hit;

  assign grpSel  = regAddr[2 +: GRP_IDX_W];
  assign bankSel = bank_e'(regAddr[REG_ADDR_W-1 -: 2]);
  // word-aligned accesses to an existing group only (R1)
  assign hit     = ({1'b0, grpSel} < GROUP_LIMIT) && (regAddr[1:0] == 2'b00);

  always_comb begin
    strobe        = '0;
    strobe.grp    = grpSel;
    strobe.grpHit = hit;
    strobe.rdBank = bankSel;
    strobe.wrSts  = regWe && hit && (bankSel == BANK_STS);
    strobe.wrIen  = regWe && hit && (bankSel == BANK_IEN);
    strobe.wrWsts = regWe && hit && (bankSel == BANK_WSTS);
    strobe.wrWen  = regWe && hit && (bankSel == BANK_WEN);
  end

endmodule

// File: rtl/gpio_evt_core.sv
module gpio_evt_core
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_SIZE = 24,
  parameter int WORD_W     = 32,
  parameter int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PADS-1:0]          padIn,
  input  logic [2*NUM_PADS-1:0]        padMode,
  input  logic [NUM_PADS-1:0]          padInv,
  input  logic [NUM_PADS-1:0]          sciRoute,
  input  regStrobe_t                   strobe,
  input  logic [WORD_W-1:0]            wrData,
  output logic [WORD_W-1:0]            rdData,
  output logic [NUM_GROUPS*WORD_W-1:0] pendingVec,
  output logic                         irqOut,
  output logic                         wakeOut,
  output logic [NUM_PADS-1:0]          stsVec,
  output logic [NUM_PADS-1:0]          wakeStsVec,
  output logic [NUM_GROUPS*WORD_W-1:0] ienFlat,
  output logic [NUM_GROUPS*WORD_W-1:0] wenFlat
);

  localparam int PAD_TOT = NUM_GROUPS * GROUP_SIZE;

  logic [NUM_PADS-1:0] wenPad;
  logic [NUM_PADS-1:0] wakeAct;
  logic [PAD_TOT-1:0]  stsPad;
  logic [PAD_TOT-1:0]  wakePad;
  logic [WORD_W-1:0]   stsWord  [NUM_GROUPS];
  logic [WORD_W-1:0]   wakeWord [NUM_GROUPS];
  logic [WORD_W-1:0]   ienWord  [NUM_GROUPS];
  logic [WORD_W-1:0]   wenWord  [NUM_GROUPS];

  // per-pad event detection and status
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int GI = p / GROUP_SIZE;
    localparam int BI = p % GROUP_SIZE;
    logic effIn, effPrev, evt, clrSts, clrWake, stsQ, wakeQ;
    evMode_e mode;

    assign mode  = evMode_e'(padMode[2*p +: 2]);
    assign effIn = padIn[p] ^ padInv[p];

    always_comb begin
      case (mode)
        MODE_LEVEL: evt = effIn;
        MODE_EDGE:  evt = effIn & ~effPrev;
        MODE_BOTH:  evt = effIn ^ effPrev;
        default:    evt = 1'b0;
      endcase
    end

    assign clrSts  = strobe.wrSts  && (strobe.grp == GRP_IDX_W'(GI)) && wrData[BI];
    assign clrWake = strobe.wrWsts && (strobe.grp == GRP_IDX_W'(GI)) && wrData[BI];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        effPrev <= 1'b0;
        stsQ    <= 1'b0;
        wakeQ   <= 1'b0;
      end else begin
        effPrev <= effIn;
        stsQ    <= (stsQ  & ~clrSts)  | evt;
        wakeQ   <= (wakeQ & ~clrWake) | evt;
      end
    end

    assign stsVec[p]     = stsQ;
    assign wakeStsVec[p] = wakeQ;
    assign wenPad[p]     = wenFlat[GI*WORD_W + BI];
    assign wakeAct[p]    = wakeQ & wenPad[p] & ~sciRoute[p];
  end

  always_comb begin
    stsPad                 = '0;
    stsPad[NUM_PADS-1:0]   = stsVec;
    wakePad                = '0;
    wakePad[NUM_PADS-1:0]  = wakeStsVec;
  end

  // per-group enable words and pending vectors
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [WORD_W-1:0] ienQ, wenQ;
    logic              selGrp;

    assign selGrp = (strobe.grp == GRP_IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ienQ <= '0;
        wenQ <= '0;
      end else begin
        if (strobe.wrIen && selGrp) ienQ <= wrData;
        if (strobe.wrWen && selGrp) wenQ <= wrData;
      end
    end

    assign stsWord[g]  = WORD_W'(stsPad[g*GROUP_SIZE +: GROUP_SIZE]);
    assign wakeWord[g] = WORD_W'(wakePad[g*GROUP_SIZE +: GROUP_SIZE]);
    assign ienWord[g]  = ienQ;
    assign wenWord[g]  = wenQ;
    assign ienFlat[g*WORD_W +: WORD_W]    = ienQ;
    assign wenFlat[g*WORD_W +: WORD_W]    = wenQ;
    assign pendingVec[g*WORD_W +: WORD_W] = stsWord[g] & ienQ;
  end

  // read mux
  always_comb begin
    rdData = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (strobe.grpHit && (strobe.grp == GRP_IDX_W'(g))) begin
        case (strobe.rdBank)
          BANK_STS:  rdData = stsWord[g];
          BANK_IEN:  rdData = ienWord[g];
          BANK_WSTS: rdData = wakeWord[g];
          default:   rdData = wenWord[g];
        endcase
      end
    end
  end

  // combined outputs, one register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqOut  <= 1'b0;
      wakeOut <= 1'b0;
    end else begin
      irqOut  <= |pendingVec;
      wakeOut <= |wakeAct;
    end
  end

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_SIZE = 24,
  parameter int WORD_W     = 32,
  parameter int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PADS-1:0]          padIn,
  input  logic [2*NUM_PADS-1:0]        padMode,
  input  logic [NUM_PADS-1:0]          padInv,
  input  logic [NUM_PADS-1:0]          sciRoute,
  input  logic                         regWe,
  input  logic [REG_ADDR_W-1:0]        regAddr,
  input  logic [WORD_W-1:0]            regWdata,
  output logic [WORD_W-1:0]            regRdata,
  output logic [NUM_GROUPS*WORD_W-1:0] pendingVec,
  output logic                         irqOut,
  output logic                         wakeOut
);

  regStrobe_t                   strobe;
  logic [NUM_PADS-1:0]          stsVec;
  logic [NUM_PADS-1:0]          wakeStsVec;
  logic [NUM_GROUPS*WORD_W-1:0] ienFlat;
  logic [NUM_GROUPS*WORD_W-1:0] wenFlat;

  gpio_evt_decode #(.NUM_GROUPS(NUM_GROUPS)) u_decode (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  gpio_evt_core #(
    .NUM_PADS   (NUM_PADS),
    .GROUP_SIZE (GROUP_SIZE),
    .WORD_W     (WORD_W),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .padIn      (padIn),
    .padMode    (padMode),
    .padInv     (padInv),
    .sciRoute   (sciRoute),
    .strobe     (strobe),
    .wrData     (regWdata),
    .rdData     (regRdata),
    .pendingVec (pendingVec),
    .irqOut     (irqOut),
    .wakeOut    (wakeOut),
    .stsVec     (stsVec),
    .wakeStsVec (wakeStsVec),
    .ienFlat    (ienFlat),
    .wenFlat    (wenFlat)
  );

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_SIZE = 24,
  parameter int WORD_W     = 32,
  parameter int NUM_GROUPS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_PADS-1:0]          padIn,
  input logic [2*NUM_PADS-1:0]        padMode,
  input logic [NUM_PADS-1:0]          padInv,
  input logic [NUM_PADS-1:0]          sciRoute,
  input logic [NUM_GROUPS*WORD_W-1:0] pendingVec,
  input logic                         irqOut,
  input logic                         wakeOut,
  input logic [NUM_PADS-1:0]          stsVec,
  input logic [NUM_PADS-1:0]          wakeStsVec,
  input logic [NUM_GROUPS*WORD_W-1:0] ienFlat,
  input logic [NUM_GROUPS*WORD_W-1:0] wenFlat
);

  localparam int PAD_TOT = NUM_GROUPS * GROUP_SIZE;

  logic [NUM_PADS-1:0] wenPadC;
  logic [PAD_TOT-1:0]  stsPadC;
  logic [PAD_TOT-1:0]  validPadC;

  always_comb begin
    for (int p = 0; p < NUM_PADS; p++)
      wenPadC[p] = wenFlat[(p / GROUP_SIZE) * WORD_W + (p % GROUP_SIZE)];
    stsPadC                 = '0;
    stsPadC[NUM_PADS-1:0]   = stsVec;
    validPadC               = '0;
    validPadC[NUM_PADS-1:0] = '1;
  end

  AST_IRQ_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == $past(|pendingVec))); // R9

  AST_WAKE_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wakeOut == $past(|(wakeStsVec & wenPadC & ~sciRoute)))); // R10

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grpChk
    logic [WORD_W-1:0] stsW, validW, pendW;
    assign stsW   = WORD_W'(stsPadC[g*GROUP_SIZE +: GROUP_SIZE]);
    assign validW = WORD_W'(validPadC[g*GROUP_SIZE +: GROUP_SIZE]);
    assign pendW  = pendingVec[g*WORD_W +: WORD_W];

    AST_PEND_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (pendW & ~(stsW & ienFlat[g*WORD_W +: WORD_W])) == '0); // R8

    AST_PEND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pendW & ~validW) == '0); // R8
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_padChk
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (padMode[2*p +: 2] == 2'd2 && !stsVec[p] && !wakeStsVec[p])
        |=> (!stsVec[p] && !wakeStsVec[p])); // R5

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (padMode[2*p +: 2] == 2'd0 && (padIn[p] ^ padInv[p])) |=> stsVec[p]); // R2
  end

endmodule

bind gpio_evt_ctrl gpio_evt_chk #(
  .NUM_PADS   (NUM_PADS),
  .GROUP_SIZE (GROUP_SIZE),
  .WORD_W     (WORD_W),
  .NUM_GROUPS (NUM_GROUPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .padIn      (padIn),
  .padMode    (padMode),
  .padInv     (padInv),
  .sciRoute   (sciRoute),
  .pendingVec (pendingVec),
  .irqOut     (irqOut),
  .wakeOut    (wakeOut),
  .stsVec     (stsVec),
  .wakeStsVec (wakeStsVec),
  .ienFlat    (ienFlat),
  .wenFlat    (wenFlat)
);

// File: tb/test_gpio_evt_ctrl.sv
`timescale 1ns/100ps
module test_gpio_evt_ctrl;

  localparam int NP = 40;
  localparam int NG = 2;
  localparam logic [7:0] A_STS = 8'h00, A_IEN = 8'h40, A_WSTS = 8'h80, A_WEN = 8'hC0;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   padIn = '0;
  logic [2*NP-1:0] padMode;
  logic [NP-1:0]   padInv = '0;
  logic [NP-1:0]   sciRoute = '0;
  logic            regWe = 1'b0;
  logic [7:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NG*32-1:0] pendingVec;
  logic            irqOut, wakeOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  gpio_evt_ctrl #(.NUM_PADS(NP)) i_gpio_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .padIn(padIn), .padMode(padMode), .padInv(padInv),
    .sciRoute(sciRoute), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pendingVec(pendingVec), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  // scoreboard
  typedef struct {
    int          kind;   // 0 read, 1 irq, 2 wake, 3 pending word
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  event  itemEv;

  initial begin : monitor
    forever begin
      @(itemEv);
      #0.2;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0:       act = regRdata;
          1:       act = {31'b0, irqOut};
          2:       act = {31'b0, wakeOut};
          default: act = pendingVec[it.sel*32 +: 32];
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.sel = sel; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    -> itemEv;
    #0.3;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    push(0, 0, exp, tag);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    push(1, 0, {31'b0, e}, tag);
  endtask

  task automatic chkWake(input logic e, input string tag);
    push(2, 0, {31'b0, e}, tag);
  endtask

  task automatic chkPend(input int g, input logic [31:0] exp, input string tag);
    push(3, g, exp, tag);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic setMode(input int p, input logic [1:0] m);
    padMode[2*p +: 2] = m;
  endtask

  task automatic quiesce();
    for (int p = 0; p < NP; p++) setMode(p, 2'd2);
    tick();
    for (int g = 0; g < NG; g++) begin
      wrReg(A_STS + 8'(4*g), 32'hFFFF_FFFF);
      wrReg(A_WSTS + 8'(4*g), 32'hFFFF_FFFF);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int p = 0; p < NP; p++) padMode[2*p +: 2] = 2'd2;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R11 reset state
    chkRead(A_STS, 32'h0, "R11 status after reset");
    chkRead(A_IEN, 32'h0, "R11 enable after reset");
    chkIrq(1'b0, "R11 irqOut after reset");
    chkWake(1'b0, "R11 wakeOut after reset");
    chkPend(0, 32'h0, "R11 pending after reset");

    // R5 off mode ignores toggles
    padIn[3] = 1'b1; tick();
    padIn[3] = 1'b0; tick();
    padIn[3] = 1'b1; tick(); tick();
    chkRead(A_STS, 32'h0, "R5 off mode status");
    chkRead(A_WSTS, 32'h0, "R5 off mode wake status");

    // R3 edge mode
    setMode(3, 2'd1); tick();
    padIn[3] = 1'b0; tick(); tick();
    chkRead(A_STS, 32'h0, "R3 falling edge ignored");
    padIn[3] = 1'b1; tick();
    chkRead(A_STS, 32'h8, "R3 rising edge sets");
    chkRead(A_WSTS, 32'h8, "R10 wake status follows event");

    // R7 write-one-to-clear
    setMode(5, 2'd1); padIn[5] = 1'b1; tick();
    chkRead(A_STS, 32'h28, "R7 two pads set");
    wrReg(A_STS, 32'h8);
    chkRead(A_STS, 32'h20, "R7 clear one pad");
    wrReg(A_STS, 32'h0);
    chkRead(A_STS, 32'h20, "R7 zero write no effect");
    wrReg(A_STS + 8'h1, 32'h20);
    chkRead(A_STS, 32'h20, "R1 misaligned write ignored");
    wrReg(A_STS, 32'h20);
    chkRead(A_STS, 32'h0, "R7 clear second pad");
    quiesce();

    // R2 level mode
    setMode(7, 2'd0); padIn[7] = 1'b1; tick();
    chkRead(A_STS, 32'h80, "R2 level sets");
    wrReg(A_STS, 32'h80);
    chkRead(A_STS, 32'h80, "R2 clear while active");
    padIn[7] = 1'b0; tick();
    wrReg(A_STS, 32'h80);
    chkRead(A_STS, 32'h0, "R2 clear after inactive");
    quiesce();

    // R6 inversion
    padIn[9] = 1'b1; padInv[9] = 1'b1; tick();
    setMode(9, 2'd1); tick();
    chkRead(A_STS, 32'h0, "R6 inverted edge quiet");
    padIn[9] = 1'b0; tick();
    chkRead(A_STS, 32'h200, "R6 falling edge via inversion");
    padIn[10] = 1'b1; padInv[10] = 1'b1; tick();
    setMode(10, 2'd0); tick();
    chkRead(A_STS, 32'h200, "R6 active-low inactive");
    padIn[10] = 1'b0; tick();
    chkRead(A_STS, 32'h600, "R6 active-low level sets");
    quiesce();

    // R4 both edges
    setMode(12, 2'd3); padIn[12] = 1'b1; tick();
    chkRead(A_STS, 32'h1000, "R4 rising sets");
    wrReg(A_STS, 32'h1000);
    chkRead(A_STS, 32'h0, "R4 cleared");
    padIn[12] = 1'b0; tick();
    chkRead(A_STS, 32'h1000, "R4 falling sets");
    quiesce();

    // R8 / R9 pending and interrupt
    setMode(14, 2'd1); padIn[14] = 1'b1; tick();
    chkPend(0, 32'h0, "R8 not enabled");
    chkIrq(1'b0, "R9 no pending");
    wrReg(A_IEN, 32'hFFFF_FFFF);
    chkPend(0, 32'h4000, "R8 enabled pending, upper bits zero");
    chkIrq(1'b0, "R9 one stage delay");
    tick();
    chkIrq(1'b1, "R9 irq asserted");
    chkRead(A_IEN, 32'hFFFF_FFFF, "R1 enable readback");
    setMode(30, 2'd1); padIn[30] = 1'b1; tick();
    chkRead(A_STS + 8'h4, 32'h40, "R1 group 1 bit mapping");
    wrReg(A_IEN + 8'h4, 32'hFFFF_FFFF);
    chkPend(1, 32'h40, "R8 group 1 pending");
    setMode(39, 2'd1); padIn[39] = 1'b1; tick();
    chkPend(1, 32'h8040, "R8 last pad, no bits past pad count");
    chkRead(A_STS + 8'h8, 32'h0, "R1 absent group reads zero");
    wrReg(A_STS, 32'h4000);
    chkPend(0, 32'h0, "R8 group 0 cleared");
    chkIrq(1'b1, "R9 group 1 still pending");
    wrReg(A_STS + 8'h4, 32'hFFFF_FFFF);
    chkPend(1, 32'h0, "R8 group 1 cleared");
    chkIrq(1'b1, "R9 delayed fall");
    tick();
    chkIrq(1'b0, "R9 irq released");
    quiesce();
    wrReg(A_IEN, 32'h0);
    wrReg(A_IEN + 8'h4, 32'h0);

    // R10 wake path
    setMode(20, 2'd1); padIn[20] = 1'b1; tick();
    chkRead(A_WSTS, 32'h0010_0000, "R10 wake status set");
    chkWake(1'b0, "R10 wake not enabled");
    wrReg(A_WEN, 32'h0010_0000);
    chkWake(1'b0, "R10 wake one stage delay");
    tick();
    chkWake(1'b1, "R10 wake asserted");
    chkIrq(1'b0, "R10 wake independent of irq enable");
    sciRoute[20] = 1'b1; tick();
    chkWake(1'b0, "R10 route flag blocks wake");
    sciRoute[20] = 1'b0; tick();
    chkWake(1'b1, "R10 wake restored");
    wrReg(A_WSTS, 32'h0010_0000);
    chkRead(A_WSTS, 32'h0, "R10 wake status cleared");
    tick();
    chkWake(1'b0, "R10 wake released");

    tick();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule